// File: doc/BRIEF.md
# Dual-Button Long-Press Reset Generator

This block turns two push-buttons into a deliberate hard-reset request. A reset comes out only when both active-low button lines are held low together for a long setup time. A two-bit select picks that time as 2, 6 or 10 seconds. Any shorter closure, or a closure of only one button, leaves the reset output untouched. Software can therefore use short presses of the same buttons as an ordinary interrupt. When the setup time is reached, the block pulls its reset line low for a fixed recovery period. The period is a build option of nominally 210 ms or 360 ms.

A digital undervoltage flag, driven by an external comparator, shares the same recovery timer. While the flag is set, reset is held low. After the flag clears, reset stays low for one more full recovery period. All durations are counted in ticks of an external prescaled enable. The parameter `TICKS_PER_SEC` says how many ticks make one second, so one build can run at real-time rates and another at a scaled-down rate.

The output is the enable of an open-drain pull-down. A 1 means the reset net is pulled low. A 0 means the net is released to its external pull-up. The block never drives the net high. The three asynchronous inputs (both buttons and the undervoltage flag) each pass through a two-flop synchronizer. The select input is treated as a static strap. Since nothing flows as a stream, all pins are plain level signals with no handshake.

Top module: `lpr_reset_gen`

## Requirements
- R1: The hold count advances by one on each tick cycle during which both synchronized button lines are low. It returns to zero in any cycle where either line is high, so a release of even one clock cycle restarts the count.
- R2: A closure of both buttons that lasts less than the selected hold time leaves `rst_pull_o` at 0. A closure of only one button, of any length, also leaves `rst_pull_o` at 0.
- R3: The hold time is `S * TICKS_PER_SEC` ticks, where S comes from `hold_sel_i`: 2'b00 gives S=2, 2'b01 gives S=6, and both 2'b10 and 2'b11 give S=10.
- R4: On the tick that completes the hold time, `rst_pull_o` rises on the next clock edge. It then stays at 1 for exactly REC ticks. REC = floor(T * TICKS_PER_SEC / 1000), with a minimum of 1, where T is 360 when `LONG_TIMEOUT` is 1 and 210 otherwise.
- R5: While the synchronized undervoltage flag is 1, `rst_pull_o` is 1. After the flag clears, `rst_pull_o` stays at 1 for a further REC ticks.
- R6: If both buttons are still held when a pulse has been issued, no further pulse starts until at least one button has been released. After such a release, a fresh full hold time is required.
- R7: While `rst_ni` is low, `rst_pull_o` is 1. After `rst_ni` rises, it stays at 1 for REC ticks and then drops to 0.
- R8: Hold and recovery counts change only in cycles where `tick_i` is 1. With `tick_i` at 0, a held press never completes and an active pulse never ends.
- R9: Each button line and the undervoltage flag pass through two synchronizer flops. With `tick_i` held at 1, a press of both buttons raises `rst_pull_o` after HOLD+2 clock cycles, where HOLD is the hold time in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset of the block |
| tick_i | input | 1 | Prescaled time-base enable; one pulse is one tick |
| btn_a_ni | input | 1 | First push-button, active low, asynchronous |
| btn_b_ni | input | 1 | Second push-button, active low, asynchronous |
| hold_sel_i | input | 2 | Hold-time select strap (00: 2 s, 01: 6 s, 10/11: 10 s) |
| uv_i | input | 1 | Undervoltage flag from an external comparator, active high, asynchronous |
| rst_pull_o | output | 1 | Open-drain pull-down enable; 1 pulls the reset net low |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 50 and `LONG_TIMEOUT` = 1. With these values the three hold times become 100, 300 and 500 ticks and the recovery period becomes 18 ticks. Every select code, every pulse boundary and the re-arm after a release therefore fall within a few hundred cycles. Because the hold windows are that short, a long constrained-random run with gated ticks and rare undervoltage events completes many full press-to-pulse sequences. That run is compared cycle by cycle with a bench-side model of the requirements.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  // Hold-time select strap codes.
  typedef enum logic [1:0] {
    HOLD_SHORT    = 2'b00,
    HOLD_MID      = 2'b01,
    HOLD_LONG     = 2'b10,
    HOLD_LONG_ALT = 2'b11
  } hold_sel_e;

  localparam int unsigned SHORT_SEC = 2;
  localparam int unsigned MID_SEC   = 6;
  localparam int unsigned LONG_SEC  = 10;

  // Nominal recovery lengths in milliseconds for the two build options.
  localparam int unsigned REC_MS_SHORT = 210;
  localparam int unsigned REC_MS_LONG  = 360;

  function automatic int unsigned rec_ticks(input bit long_opt, input int unsigned tps);
    int unsigned t;
    t = ((long_opt ? REC_MS_LONG : REC_MS_SHORT) * tps) / 1000;
    return (t == 0) ? 1 : t;
  endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[i];
        stab_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end

endmodule

// File: rtl/lpr_hold_timer.sv
module lpr_hold_timer #(
  parameter int unsigned TICKS_PER_SEC = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       both_low_i,
  input  logic [1:0] sel_i,
  output logic       fire_o
);
  import lpr_pkg::*;

  localparam int unsigned LIM_SHORT = SHORT_SEC * TICKS_PER_SEC;
  localparam int unsigned LIM_MID   = MID_SEC * TICKS_PER_SEC;
  localparam int unsigned LIM_LONG  = LONG_SEC * TICKS_PER_SEC;
  localparam int unsigned CNT_W     = $clog2(LIM_LONG + 1);

  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(LIM_SHORT - 1);
  localparam logic [CNT_W-1:0] LAST_MID   = CNT_W'(LIM_MID - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LIM_LONG - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;
  logic             lock_q;

  // Last count value before the hold time completes, per strap setting.
  always_comb begin
    unique case (hold_sel_e'(sel_i))
      HOLD_SHORT: last_cnt = LAST_SHORT;
      HOLD_MID:   last_cnt = LAST_MID;
      default:    last_cnt = LAST_LONG;
    endcase
  end

  // ">=" keeps a strap change during a press from stranding the count.
  assign fire_o = both_low_i & tick_i & ~lock_q & (cnt_q >= last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!both_low_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (fire_o) begin
      cnt_q  <= '0;
      lock_q <= 1'b1;
    end else if (tick_i && !lock_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lpr_recovery_timer.sv
module lpr_recovery_timer #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter bit          LONG_TIMEOUT  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic fire_i,
  input  logic uv_i,
  output logic active_o
);
  import lpr_pkg::*;

  localparam int unsigned REC   = rec_ticks(LONG_TIMEOUT, TICKS_PER_SEC);
  localparam int unsigned REM_W = $clog2(REC + 1);
  localparam logic [REM_W-1:0] REC_V = REM_W'(REC);

  logic [REM_W-1:0] rem_q;

  // Reset loads a full period so the block issues its own power-on pulse.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= REC_V;
    end else if (uv_i || fire_i) begin
      rem_q <= REC_V;
    end else if (tick_i && (rem_q != '0)) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign active_o = (rem_q != '0);

endmodule

// File: rtl/lpr_reset_gen.sv
module lpr_reset_gen #(
  parameter int unsigned TICKS_PER_SEC = 1000,
  parameter bit          LONG_TIMEOUT  = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       btn_a_ni,
  input  logic       btn_b_ni,
  input  logic [1:0] hold_sel_i,
  input  logic       uv_i,
  output logic       rst_pull_o
);

  localparam int unsigned NSYNC = 3;
  // Bit order {uv, btn_b, btn_a}: buttons idle released, flag idle clear.
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b011;

  logic [NSYNC-1:0] sync_q;
  logic             both_low;
  logic             uv_sync;
  logic             hold_fire;
  logic             pull_active;

  lpr_sync #(
    .WIDTH   (NSYNC),
    .RST_VAL (SYNC_RST)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({uv_i, btn_b_ni, btn_a_ni}),
    .q_o    (sync_q)
  );

  assign both_low = ~sync_q[0] & ~sync_q[1];
  assign uv_sync  = sync_q[2];

  lpr_hold_timer #(
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .both_low_i (both_low),
    .sel_i      (hold_sel_i),
    .fire_o     (hold_fire)
  );

  lpr_recovery_timer #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .LONG_TIMEOUT  (LONG_TIMEOUT)
  ) i_rec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .fire_i   (hold_fire),
    .uv_i     (uv_sync),
    .active_o (pull_active)
  );

  assign rst_pull_o = pull_active;

endmodule

// File: rtl/lpr_reset_gen_chk.sv
module lpr_reset_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pull_i,
  input logic fire_i,
  input logic both_low_i,
  input logic uv_s_i
);

  // R1
  fire_needs_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> both_low_i);

  // R6
  no_refire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> !fire_i);

  // R5
  uv_forces_pull_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_s_i |=> pull_i);

  // R2
  rise_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_i) |-> $past(fire_i || uv_s_i));

  // R4
  fall_not_reloaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_i) |-> (!$past(uv_s_i) && !$past(fire_i)));

endmodule

bind lpr_reset_gen lpr_reset_gen_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pull_i     (rst_pull_o),
  .fire_i     (hold_fire),
  .both_low_i (both_low),
  .uv_s_i     (uv_sync)
);

// File: tb/test_lpr_reset_gen.sv
module test_lpr_reset_gen;

  localparam int unsigned TPS  = 50;
  localparam bit          LONG = 1'b1;
  localparam int          REC  = 18;   // 360 * 50 / 1000
  localparam int          H2   = 100;
  localparam int          H6   = 300;
  localparam int          H10  = 500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       btn_a = 1'b1;
  logic       btn_b = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       uv = 1'b0;
  logic       rst_pull;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  lpr_reset_gen #(
    .TICKS_PER_SEC (TPS),
    .LONG_TIMEOUT  (LONG)
  ) i_lpr_reset_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .tick_i     (tick),
    .btn_a_ni   (btn_a),
    .btn_b_ni   (btn_b),
    .hold_sel_i (sel),
    .uv_i       (uv),
    .rst_pull_o (rst_pull)
  );

  function automatic int hold_lim(input logic [1:0] s);
    case (s)
      2'b00:   return H2;
      2'b01:   return H6;
      default: return H10;
    endcase
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // Reference model of the requirements, one step per clock edge.
  logic [1:0] m_b1, m_b2;
  logic       m_u1, m_u2;
  int         m_cnt;
  bit         m_lock;
  int         m_rec;

  always @(posedge clk or negedge rst_n) begin : model
    bit f;
    f = 1'b0;
    if (!rst_n) begin
      m_b1 <= 2'b11; m_b2 <= 2'b11; m_u1 <= 1'b0; m_u2 <= 1'b0;
      m_cnt <= 0; m_lock <= 1'b0; m_rec <= REC;
    end else begin
      m_b1 <= {btn_b, btn_a};
      m_b2 <= m_b1;
      m_u1 <= uv;
      m_u2 <= m_u1;
      if (m_b2 != 2'b00) begin
        m_cnt <= 0; m_lock <= 1'b0;
      end else if (tick && !m_lock) begin
        if (m_cnt >= hold_lim(sel) - 1) begin
          f = 1'b1; m_cnt <= 0; m_lock <= 1'b1;
        end else begin
          m_cnt <= m_cnt + 1;
        end
      end
      if (m_u2 || f)                 m_rec <= REC;
      else if (tick && m_rec != 0)   m_rec <= m_rec - 1;
    end
  end

  // Cycle-by-cycle comparison against the model (R1 through R9 together).
  always @(negedge clk) begin
    if (rst_n) check_eq("R1 model compare", int'(rst_pull), int'(m_rec != 0));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_tb();
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(input int maxc, output int d);
    d = 0;
    while (!rst_pull && d < maxc) begin
      @(negedge clk);
      d++;
    end
  endtask

  task automatic count_high(output int w);
    w = 0;
    while (rst_pull && w < 10000) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (rst_pull) seen = 1'b1;
    end
  endtask

  initial begin
    int  d, w;
    bit  s1, s2;
    void'($urandom(32'd20240607));

    // R7: reset state and power-on pulse
    cycles(3);
    check_eq("R7 pull during reset", int'(rst_pull), 1);
    rst_n = 1'b1;
    count_high(w);
    check_eq("R7 power-on pulse length", w, REC);

    // R2: short closure of both buttons
    btn_a = 1'b0; btn_b = 1'b0;
    quiet(50, s1);
    btn_a = 1'b1; btn_b = 1'b1;
    quiet(10, s2);
    check_eq("R2 short press ignored", int'(s1 | s2), 0);

    // R2: one button held for longer than the hold time
    btn_a = 1'b0;
    quiet(150, s1);
    btn_a = 1'b1;
    btn_b = 1'b0;
    quiet(150, s2);
    btn_b = 1'b1;
    check_eq("R2 single button ignored", int'(s1 | s2), 0);
    cycles(5);

    // R1: one-cycle release restarts the count
    btn_a = 1'b0; btn_b = 1'b0;
    quiet(60, s1);
    btn_a = 1'b1;
    @(negedge clk);
    btn_a = 1'b0;
    quiet(60, s2);
    btn_a = 1'b1; btn_b = 1'b1;
    check_eq("R1 release restarts count", int'(s1 | s2), 0);
    cycles(5);

    // R9 / R1 / R4: full press with sel 00
    btn_a = 1'b0; btn_b = 1'b0;
    wait_rise(H2 + 20, d);
    check_eq("R9 press to pull latency", d, H2 + 2);
    count_high(w);
    check_eq("R4 pulse length", w, REC);
    // R6: still held, no new pulse
    quiet(3 * REC, s1);
    check_eq("R6 no pulse while still held", int'(s1), 0);
    btn_a = 1'b1; btn_b = 1'b1;
    cycles(5);
    btn_a = 1'b0; btn_b = 1'b0;
    wait_rise(H2 + 20, d);
    check_eq("R6 rearm after release", d, H2 + 2);
    count_high(w);
    btn_a = 1'b1; btn_b = 1'b1;
    cycles(5);

    // R3: each select code
    for (int s = 1; s < 4; s++) begin
      sel = 2'(s);
      cycles(2);
      btn_a = 1'b0; btn_b = 1'b0;
      quiet(hold_lim(sel) - 10, s1);
      btn_a = 1'b1; btn_b = 1'b1;
      quiet(5, s2);
      check_eq("R3 press below selected hold", int'(s1 | s2), 0);
      btn_a = 1'b0; btn_b = 1'b0;
      wait_rise(hold_lim(sel) + 20, d);
      check_eq("R3 selected hold time", d, hold_lim(sel) + 2);
      count_high(w);
      btn_a = 1'b1; btn_b = 1'b1;
      cycles(5);
    end
    sel = 2'b00;

    // R5: undervoltage holds and stretches reset
    uv = 1'b1;
    cycles(3);
    check_eq("R5 pull during undervoltage", int'(rst_pull), 1);
    cycles(20);
    check_eq("R5 pull still held", int'(rst_pull), 1);
    uv = 1'b0;
    count_high(w);
    check_eq("R5 stretch after clear", w, REC + 2);

    // R8: no ticks, no progress
    tick = 1'b0;
    btn_a = 1'b0; btn_b = 1'b0;
    quiet(3 * H2, s1);
    check_eq("R8 hold frozen without ticks", int'(s1), 0);
    tick = 1'b1;
    wait_rise(H2 + 20, d);
    check_eq("R8 hold resumes on ticks", d, H2);
    tick = 1'b0;
    cycles(40);
    check_eq("R8 pulse frozen without ticks", int'(rst_pull), 1);
    tick = 1'b1;
    count_high(w);
    check_eq("R8 pulse resumes on ticks", w, REC);
    btn_a = 1'b1; btn_b = 1'b1;
    cycles(5);

    // Constrained random phase, checked against the model each cycle.
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if ($urandom % 300 == 0) btn_a = ~btn_a;
      if ($urandom % 300 == 0) btn_b = ~btn_b;
      tick = ($urandom % 4) != 0;
      if ($urandom % 4000 == 0) uv = ~uv;
      if ($urandom % 6000 == 0) sel = 2'($urandom % 4);
    end
    uv = 1'b0; tick = 1'b1; btn_a = 1'b1; btn_b = 1'b1;
    cycles(REC + 30);
    check_eq("R5 released after random phase", int'(rst_pull), 0);

    finish_tb();
  end

endmodule